// File: doc/BRIEF.md
# USB Host Transmit Prefill Scheduler

This block sits in the transmit path of a USB host controller. It decides when the controller may start loading its transmit latency FIFO for an OUT or SETUP packet, and when that packet may start on the bus.

A new packet is admitted to prefill only if the time left in the current (micro)frame covers a safety margin plus a programmable fill allowance. During prefill, the block counts the data bursts that the system-bus side posts into the FIFO. Once a programmable number of bursts is buffered, it starts the packet on the bus.

If the remaining frame time drops below the safety margin while prefill is still running, the attempt backs off. The block then asks for the partial packet to be discarded from the FIFO and adds one to a saturating health counter. It waits for the next start-of-frame before it tries again.

Top module: `txfill_sched`

## Requirements
- R1: After reset, every output is low and the health count is zero.
- R2: In the idle state, with no start-of-frame wait pending, a pending packet (`pkt_req_i` high) with `time_left_i >= safe_time_i + fill_allow_i` at a clock edge raises `prefill_en_o` from the next cycle. Otherwise the block stays idle and checks again at each edge.
- R3: During prefill, `time_left_i < safe_time_i` at an edge aborts the attempt. In the next cycle `prefill_en_o` is low and `backoff_o` is high for exactly one cycle. An abort takes priority over a burst strobe in the same cycle.
- R4: `discard_o` pulses in the same cycle as `backoff_o`, and only then.
- R5: Bursts are counted only during prefill, starting from zero on each admission. At the edge where a burst brings the count to the effective threshold, the block leaves prefill. In the next cycle `tx_start_o` pulses for one cycle and `prefill_en_o` is low.
- R6: The effective threshold is the value of `thres_i` (6 bits), raised to 2 when the value is 0 or 1. It is 63 when `stream_dis_i` is high, whatever the value of `thres_i`.
- R7: Each abort adds one to `health_o` in the same cycle that `backoff_o` is seen. The count holds at all ones and does not wrap.
- R8: `health_clr_i` high at an edge makes `health_o` zero in the next cycle. A clear takes priority over an abort in the same cycle.
- R9: After an abort, no new prefill starts until `sof_i` is seen high at a later edge. A `sof_i` at the abort edge itself does not release the wait.
- R10: After the start, the block stays in the transmit state and ignores bursts until `pkt_req_i` is low at an edge. It then returns to idle, and a new admission can follow at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame pulse |
| time_left_i | input | TIME_W | Time units left in the current (micro)frame |
| safe_time_i | input | TIME_W | Safety margin below which prefill is aborted |
| fill_allow_i | input | TIME_W | Fill-time allowance added to the margin for admission |
| pkt_req_i | input | 1 | A transmit packet is pending |
| burst_i | input | 1 | One data burst posted to the latency FIFO |
| thres_i | input | THR_W | Programmed burst threshold |
| stream_dis_i | input | 1 | Forces the threshold to its maximum |
| health_clr_i | input | 1 | Clears the health count |
| prefill_en_o | output | 1 | Prefill in progress |
| tx_start_o | output | 1 | One-cycle pulse: packet may start on the bus |
| backoff_o | output | 1 | One-cycle pulse: prefill attempt aborted |
| discard_o | output | 1 | One-cycle pulse: drop the partial packet from the FIFO |
| health_o | output | HEALTH_W | Saturating back-off count |

## Verification
Every result here is registered once. For any input pattern sampled at an edge, `prefill_en_o`, `tx_start_o`, `backoff_o`, `discard_o` and `health_o` are due in the cycle that begins at that edge.

The bench drives its inputs at the falling clock edge. A behavioural model updates at the rising edge from the same sampled inputs, and the bench compares all outputs with it at the next falling edge. No result is therefore read before or after its due cycle.

Directed checks are placed on the exact cycles after an abort, a threshold hit, a clear and a start-of-frame release.

// File: rtl/txfill_sched_pkg.sv
package txfill_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PREFILL = 2'd1,
    ST_XMIT    = 2'd2
  } sched_state_e;
endpackage

// File: rtl/txfill_thresh.sv
module txfill_thresh #(
  parameter int THR_W   = 6,
  parameter int THR_MIN = 2
) (
  input  logic [THR_W-1:0] thres_i,
  input  logic             stream_dis_i,
  output logic [THR_W-1:0] thr_eff_o
);
  localparam logic [THR_W-1:0] ThrMax = {THR_W{1'b1}};
  localparam logic [THR_W-1:0] ThrLo  = THR_W'(THR_MIN);

  always_comb begin
    if (stream_dis_i)          thr_eff_o = ThrMax;
    else if (thres_i < ThrLo)  thr_eff_o = ThrLo;
    else                       thr_eff_o = thres_i;
  end
endmodule

// File: rtl/txfill_health.sv
module txfill_health #(
  parameter int HEALTH_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                inc_i,
  input  logic                clr_i,
  output logic [HEALTH_W-1:0] cnt_o
);
  localparam logic [HEALTH_W-1:0] CntMax = {HEALTH_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_o <= '0;
    else if (clr_i)                    cnt_o <= '0;
    else if (inc_i && cnt_o != CntMax) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/txfill_fsm.sv
module txfill_fsm
  import txfill_sched_pkg::*;
#(
  parameter int TIME_W = 14,
  parameter int THR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic [TIME_W-1:0] time_left_i,
  input  logic [TIME_W-1:0] safe_time_i,
  input  logic [TIME_W-1:0] fill_allow_i,
  input  logic              pkt_req_i,
  input  logic              burst_i,
  input  logic [THR_W-1:0]  thr_eff_i,
  output logic              abort_o,
  output logic              prefill_en_o,
  output logic              tx_start_o,
  output logic              backoff_o
);
  localparam int SumW = TIME_W + 1;
  localparam int CntW = THR_W + 1;

  sched_state_e state_q, state_d;
  logic [THR_W-1:0] cnt_q, cnt_d;
  logic wait_sof_q, wait_sof_d;
  logic start_d;
  logic [SumW-1:0] need_time;
  logic [CntW-1:0] cnt_inc;
  logic admit;

  assign need_time = {1'b0, safe_time_i} + {1'b0, fill_allow_i};
  assign admit     = pkt_req_i && !wait_sof_q && ({1'b0, time_left_i} >= need_time);
  assign abort_o   = (state_q == ST_PREFILL) && (time_left_i < safe_time_i);
  assign cnt_inc   = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    start_d = 1'b0;
    unique case (state_q)
      ST_IDLE: if (admit) begin
        state_d = ST_PREFILL;
        cnt_d   = '0;
      end
      ST_PREFILL: begin
        if (abort_o) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (burst_i) begin
          cnt_d = cnt_inc[THR_W-1:0];
          if (cnt_inc >= {1'b0, thr_eff_i}) begin
            state_d = ST_XMIT;
            start_d = 1'b1;
          end
        end
      end
      ST_XMIT: if (!pkt_req_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // abort arms the wait; a later SOF releases it
  always_comb begin
    if (abort_o)    wait_sof_d = 1'b1;
    else if (sof_i) wait_sof_d = 1'b0;
    else            wait_sof_d = wait_sof_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      wait_sof_q <= 1'b0;
      tx_start_o <= 1'b0;
      backoff_o  <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      wait_sof_q <= wait_sof_d;
      tx_start_o <= start_d;
      backoff_o  <= abort_o;
    end
  end

  assign prefill_en_o = (state_q == ST_PREFILL);
endmodule

// File: rtl/txfill_sched.sv
module txfill_sched #(
  parameter int TIME_W   = 14,
  parameter int THR_W    = 6,
  parameter int HEALTH_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sof_i,
  input  logic [TIME_W-1:0]   time_left_i,
  input  logic [TIME_W-1:0]   safe_time_i,
  input  logic [TIME_W-1:0]   fill_allow_i,
  input  logic                pkt_req_i,
  input  logic                burst_i,
  input  logic [THR_W-1:0]    thres_i,
  input  logic                stream_dis_i,
  input  logic                health_clr_i,
  output logic                prefill_en_o,
  output logic                tx_start_o,
  output logic                backoff_o,
  output logic                discard_o,
  output logic [HEALTH_W-1:0] health_o
);
  logic [THR_W-1:0] thr_eff;
  logic abort;

  txfill_thresh #(.THR_W(THR_W), .THR_MIN(2)) thresh_i (
    .thres_i      (thres_i),
    .stream_dis_i (stream_dis_i),
    .thr_eff_o    (thr_eff)
  );

  txfill_fsm #(.TIME_W(TIME_W), .THR_W(THR_W)) fsm_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sof_i        (sof_i),
    .time_left_i  (time_left_i),
    .safe_time_i  (safe_time_i),
    .fill_allow_i (fill_allow_i),
    .pkt_req_i    (pkt_req_i),
    .burst_i      (burst_i),
    .thr_eff_i    (thr_eff),
    .abort_o      (abort),
    .prefill_en_o (prefill_en_o),
    .tx_start_o   (tx_start_o),
    .backoff_o    (backoff_o)
  );

  txfill_health #(.HEALTH_W(HEALTH_W)) health_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (abort),
    .clr_i  (health_clr_i),
    .cnt_o  (health_o)
  );

  assign discard_o = backoff_o;
endmodule

// File: rtl/txfill_sched_chk.sv
module txfill_sched_chk #(
  parameter int TIME_W   = 14,
  parameter int THR_W    = 6,
  parameter int HEALTH_W = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [TIME_W-1:0]   time_left_i,
  input logic [TIME_W-1:0]   safe_time_i,
  input logic [TIME_W-1:0]   fill_allow_i,
  input logic                pkt_req_i,
  input logic                health_clr_i,
  input logic                prefill_en_o,
  input logic                tx_start_o,
  input logic                backoff_o,
  input logic                discard_o,
  input logic [HEALTH_W-1:0] health_o
);
  localparam logic [HEALTH_W-1:0] HMax = {HEALTH_W{1'b1}};

  a_r3_abort_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prefill_en_o && time_left_i < safe_time_i) |=> (backoff_o && !prefill_en_o));

  a_r3_backoff_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backoff_o |=> !backoff_o);

  a_r4_discard_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prefill_en_o && time_left_i < safe_time_i) |=> discard_o);

  a_r2_admit_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prefill_en_o) |-> ($past(pkt_req_i) &&
      ({1'b0, $past(time_left_i)} >= {1'b0, $past(safe_time_i)} + {1'b0, $past(fill_allow_i)})));

  a_r5_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);

  a_r5_start_not_prefill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> !prefill_en_o);

  a_r7_health_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prefill_en_o && time_left_i < safe_time_i && !health_clr_i && health_o != HMax)
      |=> (health_o == $past(health_o) + 1'b1));

  a_r7_health_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (health_o == HMax && !health_clr_i) |=> (health_o == HMax));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    health_clr_i |=> (health_o == '0));
endmodule

bind txfill_sched txfill_sched_chk #(
  .TIME_W(TIME_W), .THR_W(THR_W), .HEALTH_W(HEALTH_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .time_left_i  (time_left_i),
  .safe_time_i  (safe_time_i),
  .fill_allow_i (fill_allow_i),
  .pkt_req_i    (pkt_req_i),
  .health_clr_i (health_clr_i),
  .prefill_en_o (prefill_en_o),
  .tx_start_o   (tx_start_o),
  .backoff_o    (backoff_o),
  .discard_o    (discard_o),
  .health_o     (health_o)
);

// File: tb/txfill_sched_tb_top.sv
module txfill_sched_tb_top;
  localparam int TIME_W = 14;
  localparam int THR_W = 6;
  localparam int HEALTH_W = 6;
  localparam int HMAX = (1 << HEALTH_W) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sof_i = 1'b0;
  logic [TIME_W-1:0] time_left_i = '0;
  logic [TIME_W-1:0] safe_time_i = 14'd100;
  logic [TIME_W-1:0] fill_allow_i = 14'd200;
  logic pkt_req_i = 1'b0;
  logic burst_i = 1'b0;
  logic [THR_W-1:0] thres_i = '0;
  logic stream_dis_i = 1'b0;
  logic health_clr_i = 1'b0;
  logic prefill_en_o, tx_start_o, backoff_o, discard_o;
  logic [HEALTH_W-1:0] health_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  txfill_sched #(.TIME_W(TIME_W), .THR_W(THR_W), .HEALTH_W(HEALTH_W)) dut_i (.*);

  // behavioural reference model
  int m_state = 0;  // 0 idle, 1 prefill, 2 transmit
  int m_cnt = 0, m_wait = 0, m_health = 0, m_tx = 0, m_bo = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_cnt = 0; m_wait = 0; m_health = 0; m_tx = 0; m_bo = 0;
    end else begin
      int thr, nh, nw;
      thr = stream_dis_i ? 63 : (int'(thres_i) < 2 ? 2 : int'(thres_i));
      nh = m_health; nw = m_wait; m_tx = 0; m_bo = 0;
      case (m_state)
        0: if (pkt_req_i && m_wait == 0 &&
               int'(time_left_i) >= int'(safe_time_i) + int'(fill_allow_i)) begin
             m_state = 1; m_cnt = 0;
           end
        1: if (int'(time_left_i) < int'(safe_time_i)) begin
             m_state = 0; m_cnt = 0; m_bo = 1; nw = 1;
             if (nh < HMAX) nh = nh + 1;
           end else if (burst_i) begin
             m_cnt = m_cnt + 1;
             if (m_cnt >= thr) begin m_state = 2; m_tx = 1; end
           end
        default: if (!pkt_req_i) m_state = 0;
      endcase
      if (m_bo == 0 && sof_i) nw = 0;
      if (health_clr_i) nh = 0;
      m_health = nh; m_wait = nw;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (rst_ni && !done) begin
    chk(prefill_en_o == (m_state == 1), "R2/R3 prefill_en_o", prefill_en_o, m_state == 1);
    chk(tx_start_o == m_tx[0], "R5 tx_start_o", tx_start_o, m_tx);
    chk(backoff_o == m_bo[0], "R3 backoff_o", backoff_o, m_bo);
    chk(discard_o == m_bo[0], "R4 discard_o", discard_o, m_bo);
    chk(int'(health_o) == m_health, "R7/R8 health_o", health_o, m_health);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(2);
    chk(!prefill_en_o && !tx_start_o && !backoff_o && !discard_o && health_o == 0,
        "R1 reset state", {prefill_en_o, tx_start_o, backoff_o, discard_o}, 0);
    rst_ni = 1'b1;
    cyc(1);
    chk(!prefill_en_o && health_o == 0, "R1 after release", prefill_en_o, 0);

    // R2: not enough time (needs 300)
    time_left_i = 14'd299; pkt_req_i = 1'b1; cyc(3);
    chk(!prefill_en_o, "R2 deferred", prefill_en_o, 0);
    time_left_i = 14'd300; cyc(1);
    chk(prefill_en_o, "R2 admitted", prefill_en_o, 1);

    // R5: threshold 3
    thres_i = 6'd3;
    burst_i = 1; cyc(2); burst_i = 0; cyc(2);
    chk(prefill_en_o && !tx_start_o, "R5 below threshold", tx_start_o, 0);
    burst_i = 1; cyc(1); burst_i = 0;
    chk(tx_start_o && !prefill_en_o, "R5 start", tx_start_o, 1);
    burst_i = 1; cyc(3); burst_i = 0;
    chk(!tx_start_o, "R10 bursts ignored in transmit", tx_start_o, 0);
    pkt_req_i = 0; cyc(2);
    chk(!prefill_en_o, "R10 idle after req drop", prefill_en_o, 0);

    // R6: clamp 0 -> 2
    thres_i = 6'd0; time_left_i = 14'd1000; pkt_req_i = 1; cyc(1);
    chk(prefill_en_o, "R10 readmit", prefill_en_o, 1);
    burst_i = 1; cyc(1);
    chk(!tx_start_o, "R6 clamp one burst", tx_start_o, 0);
    cyc(1); burst_i = 0;
    chk(tx_start_o, "R6 clamp start at two", tx_start_o, 1);
    pkt_req_i = 0; cyc(2);

    // R6 stream disable + R3/R4/R7/R9 abort
    stream_dis_i = 1; thres_i = 6'd2; pkt_req_i = 1; cyc(1);
    burst_i = 1; cyc(10); burst_i = 0;
    chk(prefill_en_o && !tx_start_o, "R6 stream disable holds", tx_start_o, 0);
    time_left_i = 14'd50; sof_i = 1; cyc(1); sof_i = 0;
    chk(backoff_o && discard_o && !prefill_en_o, "R3 abort pulse", backoff_o, 1);
    chk(health_o == 1, "R7 health incremented", health_o, 1);
    time_left_i = 14'd1000; cyc(4);
    chk(!prefill_en_o, "R9 wait for SOF", prefill_en_o, 0);
    sof_i = 1; cyc(1); sof_i = 0; cyc(1);
    chk(prefill_en_o, "R9 released by SOF", prefill_en_o, 1);

    // R7 saturation
    for (int i = 0; i < HMAX + 2; i++) begin
      time_left_i = 14'd50; cyc(1);
      time_left_i = 14'd1000; sof_i = 1; cyc(1); sof_i = 0; cyc(1);
    end
    chk(health_o == HMAX, "R7 saturation", health_o, HMAX);

    // R8 clear wins over abort
    cyc(1);
    time_left_i = 14'd50; health_clr_i = 1; cyc(1); health_clr_i = 0;
    chk(health_o == 0 && backoff_o, "R8 clear beats abort", health_o, 0);
    time_left_i = 14'd1000; sof_i = 1; cyc(1); sof_i = 0; cyc(1);

    // R3 abort beats burst at threshold
    stream_dis_i = 0; thres_i = 6'd2;
    burst_i = 1; cyc(1);
    time_left_i = 14'd50; cyc(1); burst_i = 0;
    chk(backoff_o && !tx_start_o, "R3 abort over burst", tx_start_o, 0);
    chk(health_o == 1, "R7 count after clear", health_o, 1);
    time_left_i = 14'd1000; pkt_req_i = 0; cyc(3);

    summary();
  end
endmodule